// File: doc/BRIEF.md
# Status Interrupt Merge and Acknowledge

This block folds three status conditions of a network controller into one level-sensitive summary interrupt. The three conditions are a change on the link-good line, a rollover of a statistics counter, and a transmit error. A transmit error is the transmitter-enable flag dropping while the transmit-success flag is low. Each condition sets its own sticky flag. A flag drives the summary output only while its enable bit in the control register is set.

Each condition is cleared in its own way. A link flag is cleared when software drops the link enable. A rollover flag is cleared by a read of the counter register. A transmit-error flag is cleared when the host writes the transmitter-enable bit to 1, or when it drops the transmit-error enable. The link-good line is asynchronous and passes through a synchronizer before its edges are detected. The summary interrupt comes from a register, so it never glitches.

Top module: `stat_irq_merge`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it, `irq_o` is 0 and all three sticky flags are clear.
- R2: A change of `link_ok_i` in either direction sets the link flag. With `link_ie_i` high, `irq_o` goes to 1 on the fourth rising edge after the change: two synchronizer stages, one edge-detect compare, and the output register.
- R3: A 1-to-0 transition of `link_ie_i` clears the link flag on that same edge. Enabling again afterwards does not raise `irq_o`.
- R4: A one-cycle `roll_pulse_i` sets the rollover flag on the sampling edge. With `roll_ie_i` high, `irq_o` is 1 on the following edge.
- R5: `cnt_rd_i` clears the rollover flag, and `irq_o` falls on the second edge after the read. Dropping `roll_ie_i` masks the rollover flag but does not clear it.
- R6: The transmit-error flag is set on an edge where `tx_en_i` is sampled 0 after being 1 on the previous edge, provided `tx_ok_i` is 0 on that edge. If `tx_ok_i` is 1 on that edge, nothing is recorded.
- R7: The transmit-error flag is cleared by a `tx_en_wr_i` strobe, or by a 1-to-0 transition of `txerr_ie_i`.
- R8: Flags are set even while their enable is low, but `irq_o` is not raised. Setting the enable later raises `irq_o` on the next edge, unless the flag was acknowledged in the meantime.
- R9: When a set condition and that flag's clear condition occur on the same edge, the flag ends up set.
- R10: `irq_o` is the registered OR over the three sources of (flag AND enable). It is 0 on the edge after all enables are sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_ok_i | input | 1 | Link-good status, asynchronous |
| roll_pulse_i | input | 1 | One-cycle statistics counter rollover pulse |
| cnt_rd_i | input | 1 | Counter register read strobe |
| tx_en_i | input | 1 | Transmitter-enable flag |
| tx_ok_i | input | 1 | Transmit-success flag |
| tx_en_wr_i | input | 1 | Host write of 1 to the transmitter-enable bit |
| link_ie_i | input | 1 | Link-change interrupt enable |
| roll_ie_i | input | 1 | Rollover interrupt enable |
| txerr_ie_i | input | 1 | Transmit-error interrupt enable |
| irq_o | output | 1 | Summary interrupt, registered level |

## Verification
The assertions assume that all inputs except `link_ok_i` are synchronous to `clk`. They also assume that `tx_en_i` holds its value through reset, so that a fall on the first sampled edge is not counted as an error. The stimulus changes every synchronous input only on the falling clock edge. It holds `link_ok_i` and `tx_en_i` low while reset is active. Each strobe lasts exactly one cycle, so every edge-triggered set or clear fires once, on a known edge.

// File: rtl/stat_irq_pkg.sv
// Package: shared source indices and widths for the status interrupt merge.
// Assumes three sources; index order fixes the bit position in flag vectors.
package stat_irq_pkg;
    localparam int NSRC      = 3;
    localparam int IDX_LINK  = 0;
    localparam int IDX_ROLL  = 1;
    localparam int IDX_TXERR = 2;
endpackage

// File: rtl/sirq_sync.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes the input is a slow level; output is the last stage, reset to 0.
module sirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg_q;

    // Shift the asynchronous level through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d_i};
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sirq_sticky.sv
// Module: sticky event flag with set priority over clear.
// Assumes set and clear are synchronous single-cycle qualifiers.
module sirq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold the flag; a set on the same edge as a clear leaves it set.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/stat_irq_merge.sv
// Module: merges link-change, counter-rollover and transmit-error status
// into one registered interrupt level, each with its own acknowledge path.
// Assumes every input except link_ok_i is synchronous to clk.
module stat_irq_merge
    import stat_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok_i,
    input  logic roll_pulse_i,
    input  logic cnt_rd_i,
    input  logic tx_en_i,
    input  logic tx_ok_i,
    input  logic tx_en_wr_i,
    input  logic link_ie_i,
    input  logic roll_ie_i,
    input  logic txerr_ie_i,
    output logic irq_o
);
    logic            link_sync;
    logic            link_prev_q;
    logic            tx_en_prev_q;
    logic [NSRC-1:0] en_v;
    logic [NSRC-1:0] en_prev_q;
    logic [NSRC-1:0] en_fall;
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;
    logic [NSRC-1:0] flag_q;

    sirq_sync #(.STAGES(SYNC_STAGES)) u_link_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (link_ok_i),
        .q_o   (link_sync)
    );

    // Remember last synchronized link level, tx-enable and enables for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_prev_q  <= 1'b0;
            tx_en_prev_q <= 1'b0;
            en_prev_q    <= '0;
        end else begin
            link_prev_q  <= link_sync;
            tx_en_prev_q <= tx_en_i;
            en_prev_q    <= en_v;
        end
    end

    // Gather enables and their falling edges.
    always_comb begin
        en_v            = '0;
        en_v[IDX_LINK]  = link_ie_i;
        en_v[IDX_ROLL]  = roll_ie_i;
        en_v[IDX_TXERR] = txerr_ie_i;
        en_fall         = en_prev_q & ~en_v;
    end

    // Per-source set and acknowledge conditions.
    always_comb begin
        set_v            = '0;
        clr_v            = '0;
        set_v[IDX_LINK]  = link_sync ^ link_prev_q;
        clr_v[IDX_LINK]  = en_fall[IDX_LINK];
        set_v[IDX_ROLL]  = roll_pulse_i;
        clr_v[IDX_ROLL]  = cnt_rd_i;
        set_v[IDX_TXERR] = tx_en_prev_q & ~tx_en_i & ~tx_ok_i;
        clr_v[IDX_TXERR] = tx_en_wr_i | en_fall[IDX_TXERR];
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        sirq_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q_o   (flag_q[g])
        );
    end

    // Register the merged, gated summary so the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(flag_q & en_v);
    end
endmodule

// File: rtl/sirq_checker.sv
// Module: property checker for stat_irq_merge, attached by bind.
// Assumes tx_en_i holds its value across the reset release edge.
module sirq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       roll_pulse_i,
    input logic       cnt_rd_i,
    input logic       tx_en_i,
    input logic       tx_ok_i,
    input logic       tx_en_wr_i,
    input logic       link_ie_i,
    input logic       roll_ie_i,
    input logic       txerr_ie_i,
    input logic       irq_o,
    input logic [2:0] flag_q
);
    logic armed_q;

    // Mark cycles whose previous sample lies after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && flag_q == 3'b000));

    a_r4_roll_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_pulse_i && roll_ie_i) ##1 roll_ie_i |=> irq_o);

    a_r5_roll_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd_i && !roll_pulse_i) |=> !flag_q[1]);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        roll_pulse_i |=> flag_q[1]);

    a_r6_txerr_detect: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $fell(tx_en_i) && !tx_ok_i) |=> flag_q[2]);

    a_r7_txerr_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_wr_i && !(armed_q && $fell(tx_en_i) && !tx_ok_i)) |=> !flag_q[2]);

    a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_ie_i && !roll_ie_i && !txerr_ie_i) |=> !irq_o);
endmodule

bind stat_irq_merge sirq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .roll_pulse_i (roll_pulse_i),
    .cnt_rd_i     (cnt_rd_i),
    .tx_en_i      (tx_en_i),
    .tx_ok_i      (tx_ok_i),
    .tx_en_wr_i   (tx_en_wr_i),
    .link_ie_i    (link_ie_i),
    .roll_ie_i    (roll_ie_i),
    .txerr_ie_i   (txerr_ie_i),
    .irq_o        (irq_o),
    .flag_q       (flag_q)
);

// File: tb/stat_irq_merge_tb.sv
// Scoreboard bench: the driver queues expected irq levels tagged with the
// cycle they are due; a monitor pops and compares them after each edge.
module stat_irq_merge_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_ok = 1'b0, roll_pulse = 1'b0, cnt_rd = 1'b0;
    logic tx_en = 1'b0, tx_ok = 1'b0, tx_en_wr = 1'b0;
    logic link_ie = 1'b0, roll_ie = 1'b0, txerr_ie = 1'b0;
    logic irq;

    typedef struct {
        int    due;
        logic  val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    stat_irq_merge u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_ok_i    (link_ok),
        .roll_pulse_i (roll_pulse),
        .cnt_rd_i     (cnt_rd),
        .tx_en_i      (tx_en),
        .tx_ok_i      (tx_ok),
        .tx_en_wr_i   (tx_en_wr),
        .link_ie_i    (link_ie),
        .roll_ie_i    (roll_ie),
        .txerr_ie_i   (txerr_ie),
        .irq_o        (irq)
    );

    always #4 clk = ~clk;

    // Queue an expected irq level due k edges after the current one.
    task automatic expect_irq(input int k, input logic v, input string r);
        exp_t e;
        e.due = cyc + k;
        e.val = v;
        e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Monitor: count edges, then compare every item due on this edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (e.due < cyc || irq !== e.val) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: irq actual=%b expected=%b",
                             e.req, cyc, irq, e.val);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // Driver: all inputs change on the falling edge.
    initial begin
        repeat (3) tick();
        expect_irq(1, 1'b0, "R1");
        rst_n = 1'b1;
        expect_irq(1, 1'b0, "R1");
        tick(); tick();

        // R4: rollover raises irq two edges later
        roll_ie = 1'b1; tick();
        roll_pulse = 1'b1;
        expect_irq(1, 1'b0, "R4");
        expect_irq(2, 1'b1, "R4");
        tick(); roll_pulse = 1'b0; tick(); tick();

        // R5: counter read acknowledges
        cnt_rd = 1'b1;
        expect_irq(1, 1'b1, "R5");
        expect_irq(2, 1'b0, "R5");
        tick(); cnt_rd = 1'b0; tick(); tick();

        // R9: rollover and read on the same edge keep the flag set
        roll_pulse = 1'b1; cnt_rd = 1'b1;
        expect_irq(2, 1'b1, "R9");
        tick(); roll_pulse = 1'b0; cnt_rd = 1'b0; tick();
        cnt_rd = 1'b1;
        expect_irq(2, 1'b0, "R5");
        tick(); cnt_rd = 1'b0; tick(); tick();

        // R5: masking rollover does not clear it
        roll_pulse = 1'b1; tick(); roll_pulse = 1'b0; tick();
        roll_ie = 1'b0;
        expect_irq(1, 1'b0, "R5");
        tick(); roll_ie = 1'b1;
        expect_irq(1, 1'b1, "R5");
        tick(); cnt_rd = 1'b1; tick(); cnt_rd = 1'b0; tick(); tick();

        // R2: link rise
        link_ie = 1'b1; tick();
        link_ok = 1'b1;
        expect_irq(3, 1'b0, "R2");
        expect_irq(4, 1'b1, "R2");
        repeat (6) tick();

        // R3: dropping the link enable acknowledges
        link_ie = 1'b0;
        expect_irq(1, 1'b0, "R3");
        tick(); link_ie = 1'b1;
        expect_irq(1, 1'b0, "R3");
        expect_irq(2, 1'b0, "R3");
        tick(); tick(); tick();

        // R2: link fall
        link_ok = 1'b0;
        expect_irq(4, 1'b1, "R2");
        repeat (6) tick();
        link_ie = 1'b0; tick(); tick();

        // R6: tx-enable drops without success
        txerr_ie = 1'b1; tx_en = 1'b1; tick();
        tx_en = 1'b0; tx_ok = 1'b0;
        expect_irq(1, 1'b0, "R6");
        expect_irq(2, 1'b1, "R6");
        tick(); tick(); tick();

        // R7: host writes tx-enable to acknowledge
        tx_en_wr = 1'b1; tx_en = 1'b1;
        expect_irq(2, 1'b0, "R7");
        tick(); tx_en_wr = 1'b0; tick(); tick();

        // R6: drop with success is not an error
        tx_ok = 1'b1; tx_en = 1'b0;
        expect_irq(2, 1'b0, "R6");
        expect_irq(3, 1'b0, "R6");
        tick(); tx_ok = 1'b0; tick(); tick(); tick();

        // R7: dropping the tx-error enable acknowledges
        tx_en = 1'b1; tick(); tx_en = 1'b0; tick(); tick();
        txerr_ie = 1'b0;
        expect_irq(1, 1'b0, "R7");
        tick(); txerr_ie = 1'b1;
        expect_irq(1, 1'b0, "R7");
        expect_irq(2, 1'b0, "R7");
        tick(); tick(); tick();

        // R9: tx error and host write on the same edge
        tx_en = 1'b1; tick();
        tx_en = 1'b0; tx_en_wr = 1'b1;
        expect_irq(2, 1'b1, "R9");
        tick(); tx_en_wr = 1'b0; tick(); tick();
        tx_en_wr = 1'b1; tick(); tx_en_wr = 1'b0; tick(); tick();

        // R8: events latch while masked, then show when enabled
        roll_ie = 1'b0; roll_pulse = 1'b1;
        expect_irq(2, 1'b0, "R8");
        tick(); roll_pulse = 1'b0; tick(); tick();
        roll_ie = 1'b1;
        expect_irq(1, 1'b1, "R8");
        tick(); tick();

        // R10: OR of sources; irq only falls when the last one is masked
        link_ie = 1'b1; link_ok = 1'b1;
        repeat (6) tick();
        roll_ie = 1'b0;
        expect_irq(1, 1'b1, "R10");
        tick(); link_ie = 1'b0;
        expect_irq(1, 1'b0, "R10");
        tick(); tick();

        while (exp_q.size() > 0) tick();
        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule